// File: doc/BRIEF.md
# Two-Colour Raster Cursor Overlay

This unit lays a 32 by 32 pixel cursor over a stream of palette-indexed pixels. Each pixel arrives with its column, its line and its base colour index. One clock later the unit returns either that base index unchanged or one of two reserved overlay indices, 258 and 259, which sit just above the 256 ordinary palette entries. The palette lookup that follows reads the result as a 9-bit index.

Software controls the cursor through a small word-addressed register window.
- A packed position word places the cursor.
- Each of the 32 cursor rows has a transparency bitmap word and a colour-select bitmap word. Within a row, bits are consumed from the most significant end toward the least significant end.
- A general-purpose scratch register reads back with a fixed flag bit forced on.

The active line width is a configuration input. The cursor is clipped where it crosses the right edge of the active area. After reset the cursor sits far off screen, so it is invisible until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: A write to byte offset 0x8FC (word 0x23F) loads cursor X from data bits 31:16 and cursor Y from data bits 15:0.
- R2: The transparency bitmap row r is written at byte offset 0x900+4r (words 0x240..0x25F). The colour-select row r is written at byte offset 0x980+4r (words 0x260..0x27F). Row r covers display line cursor Y + r.
- R3: Reset sets cursor X and cursor Y to 0xF000, so no pixel is altered until the position is rewritten.
- R4: A pixel can be overlaid only if its line is at or after cursor Y and fewer than 32 lines after it.
- R5: A pixel can be overlaid only if its column is at or after cursor X, fewer than 32 columns after it, and below active_width. This clips the cursor at the right edge.
- R6: The pixel at column cursor X + k uses bit 31-k of its row's two bitmap words.
- R7: Where the transparency bit is 0, out_idx equals the base index with a leading 0 bit. Where it is 1, out_idx is 259 if the colour bit is 1 and 258 if it is 0.
- R8: A read of byte offset 0x818 (word 0x206) returns the last value written there ORed with 0x02000000. A read of any other offset returns zero. reg_rdata is valid the cycle after reg_rd_en.
- R9: out_valid and out_idx follow pix_valid and the pixel by exactly one clock. Both are zero after reset.
- R10: A register write affects pixels presented from the next clock onward. A pixel presented in the same cycle as the write uses the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_word | input | 10 | Word offset (byte offset divided by 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after reg_rd_en |
| active_width | input | 11 | Active pixels per line (at most 1024) |
| pix_valid | input | 1 | Pixel present |
| pix_x | input | 11 | Pixel column |
| pix_y | input | 11 | Pixel line |
| pix_idx | input | 8 | Base palette index |
| out_valid | output | 1 | Registered pixel present |
| out_idx | output | 9 | Registered output index (0..255 base, 258/259 overlay) |

## Verification
A corrupted position register shows at the ports as overlay indices on the wrong lines or columns, or as no overlay at all. The error appears on the first pixel that crosses the cursor window, one clock after that pixel is presented. A bitmap row stored under the wrong address, or a bit order reversed within a row, swaps 258, 259 and the pass-through index at specific columns. The bench places asymmetric bit patterns at the first and last columns and rows so that these faults show. A misdecoded read shows up on the very next cycle as a missing or stray 0x02000000 flag bit.

// File: rtl/cursor_pkg.sv
package cursor_pkg;
  localparam int CUR_DIM   = 32;
  localparam int ROW_W     = $clog2(CUR_DIM);
  localparam int WORD_W    = 32;
  localparam int COORD_W   = 16;
  localparam int RWORD_W   = 10;
  localparam int NPLANES   = 2;

  localparam logic [RWORD_W-1:0] POS_WORD   = 10'h23F;
  localparam logic [RWORD_W-1:0] MISC_WORD  = 10'h206;
  localparam logic [3:0]         BMP_REGION = 4'h9;

  localparam logic [WORD_W-1:0]  MISC_FORCE = 32'h0200_0000;
  localparam logic [COORD_W-1:0] OFFSCREEN  = 16'hF000;

  typedef enum logic {PLANE_MASK = 1'b0, PLANE_COLOR = 1'b1} plane_e;
endpackage

// File: rtl/cursor_row_store.sv
module cursor_row_store #(
  parameter int ROWS = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cursor_regs.sv
module cursor_regs
  import cursor_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [RWORD_W-1:0] word,
  input  logic [WORD_W-1:0]  wdata,
  output logic [WORD_W-1:0]  rdata,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y,
  output logic [NPLANES-1:0] plane_we,
  output logic [ROW_W-1:0]   row_addr
);
  logic [WORD_W-1:0] misc_q;
  logic              in_bitmap;

  assign in_bitmap = wr_en && (word[RWORD_W-1:ROW_W+1] == BMP_REGION);
  assign row_addr  = word[ROW_W-1:0];

  for (genvar p = 0; p < NPLANES; p++) begin : g_we
    assign plane_we[p] = in_bitmap && (word[ROW_W] == p[0]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_x  <= OFFSCREEN;
      cur_y  <= OFFSCREEN;
      misc_q <= '0;
    end else if (wr_en) begin
      if (word == POS_WORD) begin
        cur_x <= wdata[2*COORD_W-1:COORD_W];
        cur_y <= wdata[COORD_W-1:0];
      end
      if (word == MISC_WORD) misc_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= (word == MISC_WORD) ? (misc_q | MISC_FORCE) : '0;
  end
endmodule

// File: rtl/cursor_window.sv
module cursor_window
  import cursor_pkg::*;
#(
  parameter int XW = 11,
  parameter int YW = 11
) (
  input  logic [XW-1:0]      pix_x,
  input  logic [YW-1:0]      pix_y,
  input  logic [XW-1:0]      width,
  input  logic [COORD_W-1:0] cur_x,
  input  logic [COORD_W-1:0] cur_y,
  output logic               hit,
  output logic [ROW_W-1:0]   row,
  output logic [ROW_W-1:0]   bit_sel
);
  logic [COORD_W-1:0] px, py, wd, dx, dy;
  logic               rows_ok, cols_ok;

  assign px = COORD_W'(pix_x);
  assign py = COORD_W'(pix_y);
  assign wd = COORD_W'(width);
  assign dx = px - cur_x;
  assign dy = py - cur_y;

  assign rows_ok = (py >= cur_y) && (dy < COORD_W'(CUR_DIM));
  assign cols_ok = (cur_x < wd) && (px >= cur_x) && (dx < COORD_W'(CUR_DIM)) && (px < wd);

  assign hit     = rows_ok && cols_ok;
  assign row     = dy[ROW_W-1:0];
  assign bit_sel = ROW_W'(CUR_DIM - 1) - dx[ROW_W-1:0];
endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int XW    = 11,
  parameter int YW    = 11,
  parameter int IDX_W = 8,
  localparam int OUT_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [RWORD_W-1:0] reg_word,
  input  logic [WORD_W-1:0]  reg_wdata,
  output logic [WORD_W-1:0]  reg_rdata,
  input  logic [XW-1:0]      active_width,
  input  logic               pix_valid,
  input  logic [XW-1:0]      pix_x,
  input  logic [YW-1:0]      pix_y,
  input  logic [IDX_W-1:0]   pix_idx,
  output logic               out_valid,
  output logic [OUT_W-1:0]   out_idx
);
  localparam logic [OUT_W-1:0] OVL_BG = OUT_W'((1 << IDX_W) + 2);
  localparam logic [OUT_W-1:0] OVL_FG = OUT_W'((1 << IDX_W) + 3);

  logic [COORD_W-1:0] cur_x, cur_y;
  logic [NPLANES-1:0] plane_we;
  logic [ROW_W-1:0]   row_addr, win_row, bit_sel;
  logic               win_hit;
  logic [WORD_W-1:0]  plane_row [NPLANES];
  logic               mask_b, color_b;
  logic [OUT_W-1:0]   next_idx;

  cursor_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .word(reg_word), .wdata(reg_wdata), .rdata(reg_rdata),
    .cur_x(cur_x), .cur_y(cur_y), .plane_we(plane_we), .row_addr(row_addr)
  );

  for (genvar p = 0; p < NPLANES; p++) begin : g_plane
    cursor_row_store #(.ROWS(CUR_DIM), .W(WORD_W)) u_store (
      .clk(clk), .we(plane_we[p]), .waddr(row_addr), .wdata(reg_wdata),
      .raddr(win_row), .rdata(plane_row[p])
    );
  end

  cursor_window #(.XW(XW), .YW(YW)) u_win (
    .pix_x(pix_x), .pix_y(pix_y), .width(active_width),
    .cur_x(cur_x), .cur_y(cur_y),
    .hit(win_hit), .row(win_row), .bit_sel(bit_sel)
  );

  assign mask_b  = plane_row[PLANE_MASK][bit_sel];
  assign color_b = plane_row[PLANE_COLOR][bit_sel];

  always_comb begin
    next_idx = {1'b0, pix_idx};
    if (win_hit && mask_b) next_idx = color_b ? OVL_FG : OVL_BG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
    end else begin
      out_valid <= pix_valid;
      if (pix_valid) out_idx <= next_idx;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk
  import cursor_pkg::*;
#(
  parameter int YW    = 11,
  parameter int IDX_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               pix_valid,
  input logic [YW-1:0]      pix_y,
  input logic [IDX_W-1:0]   pix_idx,
  input logic               out_valid,
  input logic [IDX_W:0]     out_idx,
  input logic               reg_rd_en,
  input logic [RWORD_W-1:0] reg_word,
  input logic [WORD_W-1:0]  reg_rdata,
  input logic [COORD_W-1:0] cur_x,
  input logic [COORD_W-1:0] cur_y
);
  assert_reset_offscreen_R3: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cur_x == OFFSCREEN && cur_y == OFFSCREEN));

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> out_valid);

  assert_idle_follows_R9: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |=> !out_valid);

  assert_above_window_passes_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && (COORD_W'(pix_y) < cur_y)) |=> (out_idx == {1'b0, $past(pix_idx)}));

  assert_overlay_codes_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_idx[IDX_W]) |-> (out_idx[IDX_W-1:1] == {{(IDX_W-2){1'b0}}, 1'b1}));

  assert_other_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_word != MISC_WORD) |=> (reg_rdata == '0));

  assert_misc_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_en && reg_word == MISC_WORD) |=> reg_rdata[25]);
endmodule

bind cursor_overlay cursor_overlay_chk #(.YW(YW), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_y(pix_y), .pix_idx(pix_idx),
  .out_valid(out_valid), .out_idx(out_idx), .reg_rd_en(reg_rd_en),
  .reg_word(reg_word), .reg_rdata(reg_rdata), .cur_x(cur_x), .cur_y(cur_y)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] W_POS  = 10'h23F;
  localparam logic [9:0] W_MISC = 10'h206;
  localparam logic [9:0] W_MASK = 10'h240;
  localparam logic [9:0] W_COL  = 10'h260;

  typedef struct packed {
    logic [10:0] x;
    logic [10:0] y;
    logic [7:0]  idx;
    logic [8:0]  exp;
    logic [3:0]  req;
  } vec_t;

  // Cursor at (100,50), width 640.
  // Row 0: mask F0000001, colour A0000000. Row 31: mask 80000000, colour 80000000.
  localparam int NVEC = 12;
  localparam vec_t VEC [NVEC] = '{
    '{11'd100, 11'd50, 8'h11, 9'd259,  4'd6},  // R6 first column, bit 31
    '{11'd101, 11'd50, 8'h12, 9'd258,  4'd7},  // R7 colour bit 0
    '{11'd102, 11'd50, 8'h13, 9'd259,  4'd7},
    '{11'd104, 11'd50, 8'h14, 9'h014,  4'd7},  // mask 0 passes through
    '{11'd131, 11'd50, 8'h15, 9'd258,  4'd6},  // last column, bit 0
    '{11'd132, 11'd50, 8'h16, 9'h016,  4'd5},  // R5 one past the cursor
    '{11'd99,  11'd50, 8'h17, 9'h017,  4'd5},
    '{11'd100, 11'd49, 8'h18, 9'h018,  4'd4},  // R4 line above
    '{11'd100, 11'd81, 8'h19, 9'd259,  4'd4},  // last row
    '{11'd100, 11'd82, 8'h1A, 9'h01A,  4'd4},  // line below
    '{11'd103, 11'd81, 8'h1B, 9'h01B,  4'd6},
    '{11'd100, 11'd60, 8'h1C, 9'h01C,  4'd2}   // R2 zeroed row 10
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en, reg_rd_en;
  logic [9:0]  reg_word;
  logic [31:0] reg_wdata, reg_rdata;
  logic [10:0] active_width;
  logic        pix_valid;
  logic [10:0] pix_x, pix_y;
  logic [7:0]  pix_idx;
  logic        out_valid;
  logic [8:0]  out_idx;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_word(reg_word), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .active_width(active_width), .pix_valid(pix_valid), .pix_x(pix_x),
    .pix_y(pix_y), .pix_idx(pix_idx), .out_valid(out_valid), .out_idx(out_idx)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] w, input logic [31:0] d);
    @(negedge clk);
    pix_valid = 1'b0;
    reg_wr_en = 1'b1; reg_word = w; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [9:0] w, input logic [31:0] exp);
    @(negedge clk);
    pix_valid = 1'b0;
    reg_rd_en = 1'b1; reg_word = w;
    @(posedge clk); #1;
    reg_rd_en = 1'b0;
    check(req, reg_rdata, exp);
  endtask

  task automatic pix(input string req, input int x, input int y, input logic [7:0] idx,
                     input logic [8:0] exp);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 11'(x); pix_y = 11'(y); pix_idx = idx;
    @(posedge clk); #1;
    check(req, {23'd0, out_idx}, {23'd0, exp});
  endtask

  task automatic fill_rows(input logic [31:0] m, input logic [31:0] c);
    for (int r = 0; r < 32; r++) begin
      wr(W_MASK + 10'(r), m);
      wr(W_COL + 10'(r), c);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; reg_wr_en = 1'b0; reg_rd_en = 1'b0; reg_word = '0; reg_wdata = '0;
    active_width = 11'd640; pix_valid = 1'b0; pix_x = '0; pix_y = '0; pix_idx = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R9 reset out_idx", {23'd0, out_idx}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3: every row opaque, but the cursor is still off screen after reset
    fill_rows(32'hFFFF_FFFF, 32'h0);
    pix("R3 origin", 0, 0, 8'h42, 9'h042);
    pix("R3 corner", 639, 767, 8'h43, 9'h043);

    // Table setup
    fill_rows(32'h0, 32'h0);
    wr(W_MASK, 32'hF000_0001);
    wr(W_COL, 32'hA000_0000);
    wr(W_MASK + 10'd31, 32'h8000_0000);
    wr(W_COL + 10'd31, 32'h8000_0000);
    wr(W_POS, {16'd100, 16'd50});
    for (int i = 0; i < NVEC; i++)
      pix($sformatf("R%0d table[%0d]", VEC[i].req, i),
          int'(VEC[i].x), int'(VEC[i].y), VEC[i].idx, VEC[i].exp);

    // R2: colour plane row 5 at its own address
    wr(W_MASK + 10'd5, 32'hFFFF_FFFF);
    wr(W_COL + 10'd5, 32'hFFFF_FFFF);
    pix("R2 row5 colour", 110, 55, 8'h21, 9'd259);
    pix("R2 row4 clear", 110, 54, 8'h22, 9'h022);

    // R5: right-edge clipping
    wr(W_MASK, 32'hFFFF_FFFF);
    wr(W_COL, 32'h0);
    active_width = 11'd110;
    pix("R5 last active column", 109, 50, 8'h23, 9'd258);
    pix("R5 clipped column", 110, 50, 8'h24, 9'h024);
    active_width = 11'd640;

    // R1: field split of the position word
    wr(W_POS, 32'h0005_0007);
    pix("R1 at X,Y", 5, 7, 8'h25, 9'd258);
    pix("R1 left of X", 4, 7, 8'h26, 9'h026);
    pix("R1 above Y", 5, 6, 8'h27, 9'h027);

    // R10: a pixel in the write cycle uses the old position
    @(negedge clk);
    reg_wr_en = 1'b1; reg_word = W_POS; reg_wdata = {16'd200, 16'd300};
    pix_valid = 1'b1; pix_x = 11'd5; pix_y = 11'd7; pix_idx = 8'h28;
    @(posedge clk); #1;
    check("R10 same-cycle old position", {23'd0, out_idx}, 32'd258);
    @(negedge clk);
    reg_wr_en = 1'b0;
    pix("R10 next pixel old spot", 5, 7, 8'h29, 9'h029);
    pix("R10 next pixel new spot", 200, 300, 8'h2A, 9'd258);

    // R8: register reads
    wr(W_MISC, 32'h0000_0055);
    rd_check("R8 misc flag", W_MISC, 32'h0200_0055);
    rd_check("R8 mask row reads zero", W_MASK, 32'h0);
    rd_check("R8 position reads zero", W_POS, 32'h0);

    // R9: idle pixel slot
    @(negedge clk);
    pix_valid = 1'b0;
    @(posedge clk); #1;
    check("R9 idle", {31'd0, out_valid}, 32'd0);
    pix("R9 valid again", 0, 0, 8'h2B, 9'h02B);
    check("R9 valid flag", {31'd0, out_valid}, 32'd1);

    if (!finished) begin
      finished = 1'b1;
      summary();
      $finish;
    end
  end
endmodule